// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block collects two hardware events into one host-visible status byte and drives a single active-low interrupt line. One event is an error pulse from a packet preparser. The other is an underflow of an audio elementary-stream ring buffer. An underflow is the moment the serial-audio read pointer becomes equal to the buffer write pointer. Each event sets its own sticky status bit. The host reads the status byte over a simple strobe interface with an 8-bit data path, and that read clears every bit it returns.

A second host register holds one mask bit per source. A masked source still records its event and still reads back as set, but it cannot pull the interrupt line low. The interrupt line is low whenever a status bit is set and its mask bit is clear. It is registered and changes on the same clock edge as the status bits.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset the status bits and mask bits are all zero, `irq_n` is 1 and `host_rdata` is 0x00.
- R2: A cycle with `pkt_err` high sets status bit 6. The bit stays set until a status read clears it.
- R3: Status bit 7 sets only in a cycle where `rd_ptr == wr_ptr` and the pointers were unequal in the cycle before. Equality that lasts many cycles sets the bit once. Equality that is already present when reset ends does not set it.
- R4: A read strobe with `host_addr` = 0 (status) loads `host_rdata` at the next edge with {bit7, bit6, 6'b000000}. The same edge clears both status bits.
- R5: If an event arrives in the same cycle as a status read, that read returns the value from before the event. The event's bit is set after the edge, so the next status read returns it.
- R6: `irq_n` is 0 exactly when some status bit is 1 and its mask bit is 0. It reflects the status and mask values that hold after each edge.
- R7: A write strobe with `host_addr` = 1 (mask) stores `host_wdata[7:6]` as the mask for status bits 7:6. A masked bit still sets on its event and still reads back as 1.
- R8: A mask read returns {mask[7:6], 2'b11, 4'b0000}. Reserved bits 5:4 read as ones whatever is written to them.
- R9: A write strobe with `host_addr` = 0 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_err | input | 1 | Preparser error pulse |
| rd_ptr | input | PTR_W | Serial-audio read pointer of the ring buffer |
| wr_ptr | input | PTR_W | Write pointer of the ring buffer |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 1 | Register select: 0 status, 1 mask |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq_n | output | 1 | Interrupt, active low, registered |

## Verification
A new event and the clearing read can land in the same cycle. For each source, the bench raises the event in the same cycle as a status read strobe. It expects that read to return the earlier, cleared contents, and the following read to return only the new bit. The interrupt line is judged across these same cycles. It must stay low after the colliding read when that source is unmasked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_SRC  = 2;
  localparam int SRC_LSB  = 6;
  localparam int SRC_PKT  = 0;
  localparam int SRC_UFL  = 1;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;
  localparam logic [DATA_W-1:0] RSV_ONES = 8'h30;

  function automatic logic [DATA_W-1:0] place_src(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[SRC_LSB +: NUM_SRC] = v;
    return r;
  endfunction
endpackage

// File: rtl/irq_ptr_cmp.sv
module irq_ptr_cmp #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic             hit
);
  logic eq;
  logic eq_q;

  assign eq = (rd_ptr == wr_ptr);

  // eq_q starts at 1 so equality held across reset is not an event
  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b1;
    else     eq_q <= eq;
  end

  assign hit = eq && !eq_q;
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] status_d,
  output logic [N-1:0] status_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // a set in the clearing cycle wins, so no event is dropped
    always_comb status_d[i] = set[i] | (status_q[i] & ~clr);

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_d,
  output logic [N-1:0] mask_q
);
  always_comb mask_d = wr_en ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_err,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_n
);
  logic               ufl_hit;
  logic [NUM_SRC-1:0] src_set;
  logic               rd_status;
  logic               wr_mask;
  logic [NUM_SRC-1:0] status_d, status_q;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic [DATA_W-1:0]  rd_mux;

  irq_ptr_cmp #(.PTR_W(PTR_W)) u_cmp (
    .clk(clk), .rst(rst), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .hit(ufl_hit)
  );

  always_comb begin
    src_set          = '0;
    src_set[SRC_PKT] = pkt_err;
    src_set[SRC_UFL] = ufl_hit;
  end

  assign rd_status = host_rd && (host_addr == ADDR_STATUS);
  assign wr_mask   = host_wr && (host_addr == ADDR_MASK);

  irq_sticky #(.N(NUM_SRC)) u_sticky (
    .clk(clk), .rst(rst), .set(src_set), .clr(rd_status),
    .status_d(status_d), .status_q(status_q)
  );

  irq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_mask),
    .wdata(host_wdata[SRC_LSB +: NUM_SRC]),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  always_comb begin
    if (host_addr == ADDR_STATUS) rd_mux = place_src(status_q);
    else                          rd_mux = place_src(mask_q) | RSV_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      irq_n      <= 1'b1;
    end else begin
      if (host_rd) host_rdata <= rd_mux;
      irq_n <= ~|(status_d & ~mask_d);
    end
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               pkt_err,
  input logic [PTR_W-1:0]   rd_ptr,
  input logic [PTR_W-1:0]   wr_ptr,
  input logic               host_rd,
  input logic               host_wr,
  input logic               host_addr,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               irq_n,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic ptr_eq;
  assign ptr_eq = (rd_ptr == wr_ptr);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (irq_n && status_q == '0 && mask_q == '0)); // R1

  AST_PKT_SETS: assert property (@(posedge clk) disable iff (rst)
    pkt_err |=> status_q[SRC_PKT]); // R2

  AST_UFL_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!ptr_eq ##1 ptr_eq) |=> status_q[SRC_UFL]); // R3

  AST_UFL_HOLD_NOSET: assert property (@(posedge clk) disable iff (rst)
    (ptr_eq ##1 (ptr_eq && host_rd && host_addr == ADDR_STATUS)) |=> !status_q[SRC_UFL]); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_STATUS && !pkt_err && !ptr_eq) |=> status_q == '0); // R4

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_STATUS && pkt_err) |=> status_q[SRC_PKT]); // R5

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(status_q & ~mask_q))); // R6

  AST_MASKED_LATCH: assert property (@(posedge clk) disable iff (rst)
    (mask_q[SRC_PKT] && pkt_err) |=> status_q[SRC_PKT]); // R7

  AST_RSV_ONES: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == ADDR_MASK) |=> host_rdata[5:4] == 2'b11); // R8

  AST_STATUS_WR_NOP: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_rd && host_addr == ADDR_STATUS && !pkt_err && !ptr_eq)
      |=> status_q == $past(status_q)); // R9
endmodule

bind irq_status_unit irq_status_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_err(pkt_err), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
  .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
  .host_rdata(host_rdata), .irq_n(irq_n), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
  localparam int PTR_W = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             pkt_err;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             host_rd, host_wr, host_addr;
  logic [7:0]       host_wdata, host_rdata;
  logic             irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_unit #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rst(rst), .pkt_err(pkt_err), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_n(irq_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    tick();
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic ptr_idle();
    rd_ptr = 4'd1; wr_ptr = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; pkt_err = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    host_addr = 1'b0; host_wdata = 8'h00;
    rd_ptr = 4'd3; wr_ptr = 4'd3;   // equal during reset
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick(); tick();
    // R1 reset state; R3 equality across reset is no event
    check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    check(host_rdata == 8'h00, "R1 rdata after reset", host_rdata, 0);
    host_read(1'b0, d);
    check(d == 8'h00, "R3 no underflow from equality held over reset", d, 0);
    host_read(1'b1, d);
    check(d == 8'h30, "R1 mask zero after reset", d, 8'h30);
    ptr_idle(); tick();

    // exhaustive sweep: mask x event pattern
    for (int m = 0; m < 4; m++) begin
      host_write(1'b1, {m[1:0], 6'b000000});   // reserved 5:4 written 0
      host_read(1'b1, d);
      check(d == {m[1:0], 6'b110000}, "R8 mask readback reserved ones", d, {m[1:0], 6'b110000});
      check(irq_n == 1'b1, "R6 idle irq_n", irq_n, 1);
      for (int e = 0; e < 4; e++) begin
        pkt_err = e[0];
        if (e[1]) wr_ptr = rd_ptr;
        tick();
        pkt_err = 1'b0; ptr_idle();
        check(irq_n == !(|(e[1:0] & ~m[1:0])), "R6 R7 irq_n under mask",
              irq_n, !(|(e[1:0] & ~m[1:0])));
        tick();
        host_read(1'b0, d);
        check(d == {e[1:0], 6'b0}, "R2 R3 R4 R7 status readback", d, {e[1:0], 6'b0});
        check(irq_n == 1'b1, "R4 irq_n released after clear", irq_n, 1);
        host_read(1'b0, d);
        check(d == 8'h00, "R4 status cleared by read", d, 0);
      end
    end
    host_write(1'b1, 8'h00);

    // R3: held equality sets once
    wr_ptr = rd_ptr;
    repeat (5) tick();
    host_read(1'b0, d);
    check(d == 8'h80, "R3 underflow on entering equality", d, 8'h80);
    tick(); tick();
    host_read(1'b0, d);
    check(d == 8'h00, "R3 held equality does not re-set", d, 0);
    ptr_idle(); tick();

    // R5: packet error colliding with read
    pkt_err = 1'b1;
    host_read(1'b0, d);
    pkt_err = 1'b0;
    check(d == 8'h00, "R5 colliding read returns prior value", d, 0);
    check(irq_n == 1'b0, "R5 R6 irq stays low after collision", irq_n, 0);
    host_read(1'b0, d);
    check(d == 8'h40, "R5 packet error kept across read", d, 8'h40);

    // R5: underflow colliding with read, plus a prior packet error
    pkt_err = 1'b1; tick(); pkt_err = 1'b0;
    wr_ptr = rd_ptr;
    host_read(1'b0, d);
    ptr_idle();
    check(d == 8'h40, "R5 read before underflow edge", d, 8'h40);
    host_read(1'b0, d);
    check(d == 8'h80, "R5 underflow kept across read", d, 8'h80);

    // R9: writes to status do nothing
    pkt_err = 1'b1; tick(); pkt_err = 1'b0;
    host_write(1'b0, 8'h00);
    host_write(1'b0, 8'hFF);
    check(irq_n == 1'b0, "R9 irq after status write", irq_n, 0);
    host_read(1'b0, d);
    check(d == 8'h40, "R9 status write ignored", d, 8'h40);

    // R7/R8: reserved bits written ones, mask packet only
    host_write(1'b1, 8'h70);
    pkt_err = 1'b1; tick(); pkt_err = 1'b0;
    check(irq_n == 1'b1, "R7 masked packet error no irq", irq_n, 1);
    host_write(1'b1, 8'h00);
    check(irq_n == 1'b0, "R6 unmask exposes latched bit", irq_n, 0);
    host_read(1'b0, d);
    check(d == 8'h40, "R7 masked bit latched", d, 8'h40);

    // R1: reset clears a pending bit and mask
    host_write(1'b1, 8'hC0);
    pkt_err = 1'b1; tick(); pkt_err = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0; tick();
    check(irq_n == 1'b1, "R1 irq after mid-run reset", irq_n, 1);
    host_read(1'b0, d);
    check(d == 8'h00, "R1 status cleared by reset", d, 0);
    host_read(1'b1, d);
    check(d == 8'h30, "R1 mask cleared by reset", d, 8'h30);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule